// File: doc/BRIEF.md
# Debug Command Decoder for a JTAG Data Register

This block sits behind one JTAG data register and turns bit-serial scans into debug actions. Bits enter on `tdi` least significant first while `shift_dr` is high. When `update_dr` arrives, the number of bits shifted since the last `capture_dr` and the value of the last-shifted (most significant) bit decide what the scan meant. If that bit is 1 and exactly three bits were shifted, the scan selects one of four debug sub-modules. If that bit is 0, a 4-bit opcode follows it and the scan is a command for the module that is currently selected.

Each module keeps a one-bit internal register index. The CPU0 module holds a 2-bit control register whose bits drive the `cpu_stall` and `cpu_reset` outputs. The bus module holds an error register: a sticky flag plus the 32-bit address of the first failing access, reported on `bus_err_valid`/`bus_err_addr`. A register is read by shifting a no-operation command. On `capture_dr` the selected register is loaded into the shift chain, and it then appears on `tdo` one bit per shift, least significant bit first.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: While `trst_n` is low, and after it is released, no module is selected (`sel_valid`=0), `cpu_stall` and `cpu_reset` are 0, the error flag is clear, every module's register index is 0, and a read returns all zeros.
- R2: A scan of exactly 3 bits whose last-shifted bit is 1 selects the module numbered by its first two bits (first bit is bit 0): 0 = bus, 1 = CPU0, 2 = CPU1, 3 = serial port. `sel_valid` and `sel_module` change only on the clock edge that samples `update_dr`.
- R3: A scan whose last-shifted bit is 1 and whose length is not 3 has no effect. Opcodes other than 0x0, 0x9 and 0xD have no effect.
- R4: A 6-bit scan of {flag 0, opcode 0xD, index}, with the index bit shifted first, sets the selected module's register index.
- R5: Opcode 0x9 writes the selected register of the selected module. Its data bits are shifted first, LSB first, ahead of the 6 command bits. Any scan length from 7 to 33 bits is accepted. Data bits that were not supplied are written as 0.
- R6: In CPU0, register 0 is the control register: bit 0 drives `cpu_stall` and bit 1 drives `cpu_reset`.
- R7: `capture_dr` loads the selected register of the selected module into the chain, and `tdo` presents it LSB first, one bit per shift. The bus error register reads as {address[31:0], flag} with the flag in bit 0. CPU0 register 0 reads as its 2 control bits. Every other register reads as 0. A NOP (opcode 0x0) changes no state.
- R8: A pulse on `bus_err_valid` while the flag is clear sets the flag and records `bus_err_addr`. Further pulses while the flag is set change neither the flag nor the address.
- R9: Writing bus register 0 with data bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag and address unchanged.
- R10: Module commands issued while no module is selected are ignored.
- R11: Writes to CPU1 or the serial port, and writes to register 1 of any module, leave `cpu_stall`, `cpu_reset` and the error register unchanged.
- R12: The module selection and each module's register index persist across scans. Reselecting a module restores its earlier index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-logic reset, active low, asynchronous assert |
| tdi | input | 1 | Serial data in, LSB first |
| capture_dr | input | 1 | Capture strobe: load selected register, clear bit count |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe: decode the scanned command |
| bus_err_valid | input | 1 | One-cycle report of a failed bus access |
| bus_err_addr | input | 32 | Address of the failed access |
| tdo | output | 1 | Serial data out, low bit of the chain |
| sel_valid | output | 1 | A module is selected |
| sel_module | output | 2 | Selected module number |
| cpu_stall | output | 1 | CPU stall request (control bit 0) |
| cpu_reset | output | 1 | CPU reset request (control bit 1) |

## Verification
Some properties are checked on every clock edge. The selection and the CPU control bits may change only on an update edge. Control bits hold while no module is selected. A set error flag and its address stay put until an update. At most one kind of command is decoded per update. The bench's scenarios cover the rest, because it depends on what was shifted in earlier: the bit-length rules for each command, the contents read back on `tdo`, write-one-to-clear versus write-zero, first-error address retention, and per-module index persistence across reselection. A randomly ordered mix of these scans is compared against a model of the requirements.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int NUM_MOD = 4;

  typedef enum logic [1:0] {
    MOD_BUS    = 2'd0,
    MOD_CPU0   = 2'd1,
    MOD_CPU1   = 2'd2,
    MOD_SERIAL = 2'd3
  } mod_e;

  localparam logic [3:0] OP_NOP    = 4'h0;
  localparam logic [3:0] OP_REG_WR = 4'h9;
  localparam logic [3:0] OP_REG_SL = 4'hD;

  typedef struct packed {
    logic       sel;    // module select decoded
    logic       idx;    // register index select decoded
    logic       wr;     // register write decoded
    mod_e       mod;    // module number for sel
    logic       index;  // index bit for idx
    logic [1:0] data;   // low write data bits
  } cmd_t;
endpackage

// File: rtl/dbgc_shifter.sv
module dbgc_shifter #(
  parameter int SR_W  = 33,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tdi,
  input  logic             capture,
  input  logic             shift,
  input  logic [SR_W-1:0]  cap_data,
  output logic [SR_W-1:0]  sr,
  output logic [CNT_W-1:0] cnt,
  output logic             tdo
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SR_W-1:0]  sr_d, sr_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (capture) begin
      sr_d  = cap_data;
      cnt_d = '0;
    end else if (shift) begin
      sr_d = {tdi, sr_q[SR_W-1:1]};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign sr  = sr_q;
  assign cnt = cnt_q;
  assign tdo = sr_q[0];
endmodule

// File: rtl/dbgc_decode.sv
module dbgc_decode import dbgc_pkg::*; #(
  parameter int SR_W  = 33,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [SR_W-1:0]  sr,
  input  logic [CNT_W-1:0] cnt,
  output cmd_t             cmd
);
  logic             flag;
  logic [3:0]       opcode;
  logic [CNT_W-1:0] lo;
  logic [SR_W-1:0]  aligned;
  logic             wr_len_ok;

  always_comb begin
    flag      = sr[SR_W-1];
    opcode    = sr[SR_W-2 -: 4];
    lo        = CNT_W'(SR_W) - cnt;
    aligned   = sr >> lo;
    wr_len_ok = (cnt >= CNT_W'(7)) && (cnt <= CNT_W'(SR_W));

    cmd       = '0;
    cmd.sel   = update && flag && (cnt == CNT_W'(3));
    cmd.mod   = mod_e'(sr[SR_W-2 -: 2]);
    cmd.idx   = update && !flag && (cnt == CNT_W'(6)) && (opcode == OP_REG_SL);
    cmd.index = sr[SR_W-6];
    cmd.wr    = update && !flag && wr_len_ok && (opcode == OP_REG_WR);
    cmd.data  = {(cnt >= CNT_W'(8)) ? aligned[1] : 1'b0, aligned[0]};
  end

  // R3: the three command kinds are told apart by length and flag
  a_r3_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.sel, cmd.idx, cmd.wr}));
endmodule

// File: rtl/dbgc_regs.sv
module dbgc_regs import dbgc_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              update,
  input  cmd_t              cmd,
  input  logic              err_valid,
  input  logic [ADDR_W-1:0] err_addr,
  output logic [ADDR_W:0]   cap_data,
  output logic              sel_valid,
  output logic [1:0]        sel_module,
  output logic [1:0]        ctrl
);
  logic              sel_valid_d, sel_valid_q;
  mod_e              sel_mod_d, sel_mod_q;
  logic [NUM_MOD-1:0] idx_d, idx_q;
  logic [1:0]        ctrl_d, ctrl_q;
  logic              flag_d, flag_q;
  logic [ADDR_W-1:0] addr_d, addr_q;

  always_comb begin
    sel_valid_d = sel_valid_q;
    sel_mod_d   = sel_mod_q;
    idx_d       = idx_q;
    ctrl_d      = ctrl_q;
    flag_d      = flag_q;
    addr_d      = addr_q;

    if (cmd.sel) begin
      sel_valid_d = 1'b1;
      sel_mod_d   = cmd.mod;
    end
    if (cmd.idx && sel_valid_q) idx_d[sel_mod_q] = cmd.index;
    if (cmd.wr && sel_valid_q) begin
      if (sel_mod_q == MOD_CPU0 && !idx_q[MOD_CPU0]) ctrl_d = cmd.data;
      if (sel_mod_q == MOD_BUS && !idx_q[MOD_BUS] && cmd.data[0]) flag_d = 1'b0;
    end
    if (err_valid && !flag_d) begin
      flag_d = 1'b1;
      addr_d = err_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid_q <= 1'b0;
      sel_mod_q   <= MOD_BUS;
      idx_q       <= '0;
      ctrl_q      <= '0;
      flag_q      <= 1'b0;
      addr_q      <= '0;
    end else begin
      sel_valid_q <= sel_valid_d;
      sel_mod_q   <= sel_mod_d;
      idx_q       <= idx_d;
      ctrl_q      <= ctrl_d;
      flag_q      <= flag_d;
      addr_q      <= addr_d;
    end
  end

  always_comb begin
    cap_data = '0;
    if (sel_valid_q && !idx_q[sel_mod_q]) begin
      if (sel_mod_q == MOD_BUS)       cap_data = {addr_q, flag_q};
      else if (sel_mod_q == MOD_CPU0) cap_data[1:0] = ctrl_q;
    end
  end

  assign sel_valid  = sel_valid_q;
  assign sel_module = sel_mod_q;
  assign ctrl       = ctrl_q;

  // R2: selection moves only on an update edge
  a_r2_sel_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable({sel_valid_q, sel_mod_q}));
  // R6: control bits move only on an update edge
  a_r6_ctrl_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(ctrl_q));
  // R10: nothing selected means control bits hold
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid_q |=> $stable(ctrl_q));
  // R8: a recorded error holds flag and address until an update
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !update) |=> (flag_q && $stable(addr_q)));
endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder import dbgc_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              bus_err_valid,
  input  logic [ADDR_W-1:0] bus_err_addr,
  output logic              tdo,
  output logic              sel_valid,
  output logic [1:0]        sel_module,
  output logic              cpu_stall,
  output logic              cpu_reset
);
  localparam int SR_W  = ADDR_W + 1;
  localparam int CNT_W = $clog2(SR_W + 2);

  logic [1:0]       rst_sync;
  logic             rst_n;
  logic [SR_W-1:0]  sr, cap_data;
  logic [CNT_W-1:0] cnt;
  cmd_t             cmd;
  logic [1:0]       ctrl;

  // asynchronous assert, synchronous release
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  dbgc_shifter #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
    .clk(tck), .rst_n(rst_n), .tdi(tdi), .capture(capture_dr),
    .shift(shift_dr), .cap_data(cap_data), .sr(sr), .cnt(cnt), .tdo(tdo)
  );

  dbgc_decode #(.SR_W(SR_W), .CNT_W(CNT_W)) u_dec (
    .clk(tck), .rst_n(rst_n), .update(update_dr), .sr(sr), .cnt(cnt), .cmd(cmd)
  );

  dbgc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(tck), .rst_n(rst_n), .update(update_dr), .cmd(cmd),
    .err_valid(bus_err_valid), .err_addr(bus_err_addr), .cap_data(cap_data),
    .sel_valid(sel_valid), .sel_module(sel_module), .ctrl(ctrl)
  );

  assign cpu_stall = ctrl[0];
  assign cpu_reset = ctrl[1];
endmodule

// File: tb/test_dbg_cmd_decoder.sv
module test_dbg_cmd_decoder;
  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic        bus_err_valid = 1'b0;
  logic [31:0] bus_err_addr = '0;
  logic        tdo, sel_valid, cpu_stall, cpu_reset;
  logic [1:0]  sel_module;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // requirement model
  bit          m_valid;
  logic [1:0]  m_mod;
  logic [3:0]  m_idx;
  logic [1:0]  m_ctrl;
  bit          m_flag;
  logic [31:0] m_addr;

  always #5 tck = ~tck;

  dbg_cmd_decoder i_dbg_cmd_decoder (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .bus_err_valid(bus_err_valid),
    .bus_err_addr(bus_err_addr), .tdo(tdo), .sel_valid(sel_valid),
    .sel_module(sel_module), .cpu_stall(cpu_stall), .cpu_reset(cpu_reset)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] exp_read();
    if (!m_valid || m_idx[m_mod]) return '0;
    if (m_mod == 2'd0) return {m_addr, m_flag};
    if (m_mod == 2'd1) return {31'b0, m_ctrl};
    return '0;
  endfunction

  task automatic model_apply(input logic [63:0] b, input int n);
    logic [3:0] op;
    logic d0, d1;
    if (n < 1) return;
    if (b[n-1]) begin
      if (n == 3) begin m_valid = 1; m_mod = b[1:0]; end
    end else if (n >= 5 && m_valid) begin
      op = b[n-2 -: 4];
      if (n == 6 && op == 4'hD) m_idx[m_mod] = b[0];
      if (op == 4'h9 && n >= 7 && n <= 33) begin
        d0 = b[0];
        d1 = (n >= 8) ? b[1] : 1'b0;
        if (m_mod == 2'd1 && !m_idx[1]) m_ctrl = {d1, d0};
        if (m_mod == 2'd0 && !m_idx[0] && d0) m_flag = 0;
      end
    end
  endtask

  task automatic model_reset();
    m_valid = 0; m_mod = 0; m_idx = 0; m_ctrl = 0; m_flag = 0; m_addr = 0;
  endtask

  task automatic scan(input logic [63:0] b, input int n, output logic [63:0] got);
    got = '0;
    @(negedge tck); capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      got[i] = tdo; shift_dr = 1'b1; tdi = b[i];
      @(negedge tck);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge tck); update_dr = 1'b0;
    model_apply(b, n);
  endtask

  task automatic do_sel(input logic [1:0] m);
    logic [63:0] g;
    scan({61'b0, 1'b1, m}, 3, g);
  endtask

  task automatic do_idx(input logic i);
    logic [63:0] g;
    scan({58'b0, 1'b0, 4'hD, i}, 6, g);
  endtask

  task automatic do_write(input logic [31:0] data, input int dl);
    logic [63:0] g, b;
    b = (64'(6'b010010) << dl) | (64'(data) & ((64'd1 << dl) - 1));
    scan(b, dl + 6, g);
  endtask

  task automatic do_read(output logic [32:0] val);
    logic [63:0] g;
    scan(64'd0, 38, g);
    val = g[32:0];
  endtask

  task automatic err_pulse(input logic [31:0] a);
    @(negedge tck); bus_err_valid = 1'b1; bus_err_addr = a;
    @(negedge tck); bus_err_valid = 1'b0;
    if (!m_flag) begin m_flag = 1; m_addr = a; end
  endtask

  task automatic tap_reset();
    @(negedge tck); trst_n = 1'b0;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    repeat (4) @(negedge tck);
    model_reset();
  endtask

  task automatic check_outs(input string req);
    check(req, {60'b0, sel_valid, sel_module, cpu_stall}, {60'b0, m_valid, m_mod, m_ctrl[0]});
    check(req, {63'b0, cpu_reset}, {63'b0, m_ctrl[1]});
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [32:0] rd;
    logic [63:0] g;
    void'($urandom(32'd20240607));
    model_reset();
    repeat (2) @(negedge tck);
    check_outs("R1 in reset");
    tap_reset();
    check_outs("R1 after reset");
    do_read(rd); check("R1 read none", 64'(rd), 64'd0);

    // R10: write with nothing selected
    do_write(32'h3, 2); check_outs("R10 unselected write");

    // R2/R6: select CPU0, set both bits, then a 1-bit write clears bit 1
    do_sel(2'd1); check_outs("R2 select cpu0");
    do_write(32'h3, 2); check_outs("R6 write 11");
    check("R6 stall", 64'(cpu_stall), 64'd1);
    do_read(rd); check("R7 read ctrl", 64'(rd), 64'(exp_read()));
    do_write(32'h0, 1); check_outs("R5 short write zero-fills");
    do_write(32'h2, 2); check("R6 reset bit", 64'(cpu_reset), 64'd1);

    // R3: 4-bit scan with top 1, and unused opcode
    scan({60'b0, 4'b1000}, 4, g); check_outs("R3 wrong-length select");
    scan({56'b0, 1'b0, 4'h3, 3'b001}, 8, g); check_outs("R3 unused opcode");

    // R11: CPU1 writes do not touch control
    do_sel(2'd2); do_write(32'h1, 2); check_outs("R11 cpu1 write");
    do_read(rd); check("R11 cpu1 reads zero", 64'(rd), 64'd0);

    // R8/R9: bus error register
    do_sel(2'd0);
    err_pulse(32'hCAFE_0123);
    do_read(rd); check("R8 error recorded", 64'(rd), {31'b0, 32'hCAFE_0123, 1'b1});
    err_pulse(32'h1111_2222);
    do_read(rd); check("R8 first address kept", 64'(rd), 64'(exp_read()));
    do_write(32'h0, 1);
    do_read(rd); check("R9 write zero no effect", 64'(rd), {31'b0, 32'hCAFE_0123, 1'b1});
    do_write(32'h1, 1);
    do_read(rd); check("R9 write one clears", 64'(rd[0]), 64'd0);

    // R4/R12: index select and persistence
    err_pulse(32'h0000_00A5);
    do_idx(1'b1); do_read(rd); check("R4 bus index 1 reads zero", 64'(rd), 64'd0);
    do_write(32'h1, 1); check("R11 reg1 write keeps flag", 64'(m_flag), 64'd1);
    do_sel(2'd1); do_read(rd); check("R12 cpu0 index kept", 64'(rd), 64'(exp_read()));
    do_sel(2'd0); do_read(rd); check("R12 bus index kept", 64'(rd), 64'd0);
    do_idx(1'b0); do_read(rd); check("R4 bus index 0", 64'(rd), {31'b0, 32'h0000_00A5, 1'b1});

    // randomized mix against the model
    for (int it = 0; it < 300; it++) begin
      int unsigned k;
      k = $urandom_range(0, 7);
      case (k)
        0: do_sel(2'($urandom_range(0, 3)));
        1: do_idx(1'($urandom_range(0, 1)));
        2, 3: do_write($urandom, $urandom_range(1, 3));
        4: err_pulse($urandom);
        5: scan(64'($urandom) | 64'h8, 4, g);
        default: begin
          do_read(rd); check("R7 random read", 64'(rd), 64'(exp_read()));
        end
      endcase
      check_outs("R12 random outputs");
    end

    tap_reset();
    check_outs("R1 second reset");
    do_sel(2'd0); do_read(rd); check("R1 error cleared", 64'(rd), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule